// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block holds the digital control of a 3½-digit dual-slope integrating converter. An internal tick is taken from the fast oscillator clock once every `DIV` clocks, and that tick advances every counter. The block runs the same measurement cycle without end: zeroing (auto-zero), then a fixed window in which the input is integrated, then a window in which a reference of the opposite sign is integrated until the comparator shows that the integrator is back at zero. The block drives one phase-select line for each switch group. It samples the single comparator bit once to find the sign of the input and again to find the zero crossing.

The time spent in de-integrate is counted directly in BCD. When de-integrate ends, the reading, the sign and an overrange flag are moved into an output latch, and the latch holds them for a whole cycle. The cycle length never changes. The zeroing phase takes whatever de-integrate time the reading left unused, so conversions come out at a constant rate. A synchronous reset starts the block at the beginning of a zeroing phase of minimum length.

Top module: `dual_slope_seq`

## Requirements
- R1: All phase timing advances on a tick that occurs once every `DIV` oscillator clocks. Every phase length, measured in clocks, is a whole number of ticks times `DIV`.
- R2: While reset is held, `az_o` is 1, all other phase lines are 0, and `done_o`, `neg_o`, `ovr_o` and `reading_o` are 0. After reset is released, the first zeroing phase lasts `CYCLE_COUNTS-INT_COUNTS-FULL_COUNTS` ticks.
- R3: Exactly one of `az_o`, `int_o`, `de_pos_o` and `de_neg_o` is 1 at all times.
- R4: The phases always run in the order zeroing, integrate, de-integrate, zeroing. Integrate lasts exactly `INT_COUNTS` ticks.
- R5: From the start of one integrate phase to the start of the next is always `CYCLE_COUNTS` ticks, whatever the input.
- R6: The sign is taken from `comp_i` on the last tick of integrate. A value of 1 means a positive input and selects `de_pos_o`. A value of 0 means a negative input and selects `de_neg_o`.
- R7: The integrator is seen at zero on the first de-integrate tick at which `comp_i` equals 0 under `de_pos_o`, or equals 1 under `de_neg_o`. De-integrate ends on that tick, and the reading is the number of earlier de-integrate ticks. De-integrate therefore lasts reading+1 ticks.
- R8: If `FULL_COUNTS` de-integrate ticks pass without a crossing, de-integrate ends. The latched reading is then `FULL_COUNTS`, `ovr_o` is 1, and de-integrate has lasted `FULL_COUNTS` ticks. A crossing seen on that last tick gives reading `FULL_COUNTS-1` with `ovr_o` 0.
- R9: The zeroing phase that follows lasts `CYCLE_COUNTS-INT_COUNTS` ticks minus the length of the de-integrate phase.
- R10: `done_o` is a one-clock pulse on the clock in which de-integrate ends. On that same clock the reading, sign and overrange flag are latched. They stay unchanged until the next pulse.
- R11: `reading_o` is packed BCD: decimal digit i sits in bits [4i+3:4i], with digit 0 the least significant.
- R12: `neg_o` is latched as 1 when the finished de-integrate used `de_neg_o`, and as 0 when it used `de_pos_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_i | input | 1 | Comparator bit, 1 when integrator output is above zero |
| az_o | output | 1 | Zeroing phase: inputs open, offset feedback closed |
| int_o | output | 1 | Input integrate phase |
| de_pos_o | output | 1 | De-integrate with reference for a positive input |
| de_neg_o | output | 1 | De-integrate with reference for a negative input |
| done_o | output | 1 | One-clock pulse when a result is latched |
| reading_o | output | 4*DIGITS | Latched magnitude, packed BCD |
| neg_o | output | 1 | Latched sign, 1 = negative |
| ovr_o | output | 1 | Latched overrange flag |

## Verification
The properties assume that `rst` is a clean synchronous level and that `comp_i` is already a settled digital level when it is sampled. The analog comparator is treated as a bit that changes between clock edges, never at one. The stimulus changes `comp_i` only on falling clock edges. It holds the bit at the sign value for all of integrate and moves it to the crossed value exactly once per de-integrate, at a falling-edge offset chosen from the target reading. This keeps every tick sample unambiguous, and the expected reading follows from that one offset alone.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [3:0] {
    PH_AZ  = 4'b0001,
    PH_INT = 4'b0010,
    PH_DEP = 4'b0100,
    PH_DEN = 4'b1000
  } phase_e;

  // Packed BCD of a binary value, up to eight decimal digits.
  function automatic logic [31:0] to_bcd(input int unsigned v);
    logic [31:0] r;
    int unsigned x;
    x = v;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsc_tick_gen.sv
module dsc_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)                 pre_q <= '0;
    else if (pre_q == PRE_LAST) pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == PRE_LAST);
endmodule

// File: rtl/dsc_bcd_count.sv
module dsc_bcd_count #(
  parameter int DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [4*DIGITS-1:0] count_o,
  output logic [4*DIGITS-1:0] next_o
);
  // Ripple decimal increment of the current value.
  always_comb begin
    logic carry;
    carry = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (carry) next_o[4*i +: 4] = (count_o[4*i +: 4] == 4'd9) ? 4'd0 : count_o[4*i +: 4] + 4'd1;
      else       next_o[4*i +: 4] = count_o[4*i +: 4];
      carry = carry & (count_o[4*i +: 4] == 4'd9);
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst || clr) count_o[4*g +: 4] <= 4'd0;
      else if (inc)   count_o[4*g +: 4] <= next_o[4*g +: 4];
    end
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int DIV          = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int FULL_COUNTS  = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int DIGITS       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                comp_i,
  output logic                az_o,
  output logic                int_o,
  output logic                de_pos_o,
  output logic                de_neg_o,
  output logic                done_o,
  output logic [4*DIGITS-1:0] reading_o,
  output logic                neg_o,
  output logic                ovr_o
);
  localparam int CW = $clog2(CYCLE_COUNTS);
  localparam int RW = 4 * DIGITS;
  localparam logic [CW-1:0] CYC_LAST = CW'(CYCLE_COUNTS - 1);
  localparam logic [CW-1:0] INT_LAST = CW'(INT_COUNTS - 1);
  localparam logic [CW-1:0] DE_LAST  = CW'(INT_COUNTS + FULL_COUNTS - 1);
  localparam logic [CW-1:0] RST_POS  = CW'(INT_COUNTS + FULL_COUNTS);

  logic          tick;
  phase_e        phase_q;
  logic [CW-1:0] cyc_q;
  logic [RW-1:0] cnt_q, cnt_nxt;
  logic          in_de, crossed, de_last, cnt_clr, cnt_inc;

  dsc_tick_gen #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  dsc_bcd_count #(.DIGITS(DIGITS)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .count_o (cnt_q),
    .next_o  (cnt_nxt)
  );

  assign in_de   = (phase_q == PH_DEP) || (phase_q == PH_DEN);
  assign crossed = (comp_i == (phase_q == PH_DEN));
  assign de_last = (cyc_q == DE_LAST);
  assign cnt_clr = tick && (phase_q == PH_INT) && (cyc_q == INT_LAST);
  assign cnt_inc = tick && in_de && !crossed;

  // Free-running cycle position; integrate begins at position zero.
  always_ff @(posedge clk) begin
    if (rst)              cyc_q <= RST_POS;
    else if (tick)        cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_AZ;
      done_o    <= 1'b0;
      reading_o <= '0;
      neg_o     <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick) begin
        unique case (phase_q)
          PH_AZ:  if (cyc_q == CYC_LAST) phase_q <= PH_INT;
          PH_INT: if (cyc_q == INT_LAST) phase_q <= comp_i ? PH_DEP : PH_DEN;
          default: begin
            if (crossed || de_last) begin
              phase_q   <= PH_AZ;
              done_o    <= 1'b1;
              reading_o <= crossed ? cnt_q : cnt_nxt;
              ovr_o     <= !crossed;
              neg_o     <= (phase_q == PH_DEN);
            end
          end
        endcase
      end
    end
  end

  assign az_o     = phase_q[0];
  assign int_o    = phase_q[1];
  assign de_pos_o = phase_q[2];
  assign de_neg_o = phase_q[3];
endmodule

// File: rtl/dsc_seq_chk.sv
module dsc_seq_chk
  import dsc_pkg::*;
#(
  parameter int DIV          = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int FULL_COUNTS  = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int DIGITS       = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                az_o,
  input logic                int_o,
  input logic                de_pos_o,
  input logic                de_neg_o,
  input logic                done_o,
  input logic [4*DIGITS-1:0] reading_o,
  input logic                neg_o,
  input logic                ovr_o
);
  localparam int RW = 4 * DIGITS;
  localparam logic [31:0] FULL_BCD32 = to_bcd(FULL_COUNTS);
  localparam logic [RW-1:0] FULL_BCD = FULL_BCD32[RW-1:0];
  localparam int PERIOD = CYCLE_COUNTS * DIV;

  logic        int_q, seen_q;
  logic [31:0] since_q;
  logic        int_rise;

  assign int_rise = int_o && !int_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= 1'b0; seen_q <= 1'b0; since_q <= '0;
    end else begin
      int_q <= int_o;
      if (int_rise) begin since_q <= '0; seen_q <= 1'b1; end
      else          since_q <= since_q + 1;
    end
  end

  a_r3_one_phase: assert property (@(posedge clk) disable iff (rst)
    $countones({az_o, int_o, de_pos_o, de_neg_o}) == 1);

  a_r4_int_after_az: assert property (@(posedge clk) disable iff (rst)
    $rose(int_o) |-> $past(az_o));

  a_r4_de_after_int: assert property (@(posedge clk) disable iff (rst)
    $rose(de_pos_o || de_neg_o) |-> $past(int_o));

  a_r5_cycle_len: assert property (@(posedge clk) disable iff (rst)
    (int_rise && seen_q) |-> (since_q == 32'(PERIOD - 1)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r10_done_at_de_end: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (az_o && $past(de_pos_o || de_neg_o)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(reading_o) && $stable(neg_o) && $stable(ovr_o)));

  a_r12_sign: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (neg_o == $past(de_neg_o)));

  a_r8_ovr_full: assert property (@(posedge clk) disable iff (rst)
    (done_o && ovr_o) |-> (reading_o == FULL_BCD));
endmodule

bind dual_slope_seq dsc_seq_chk #(
  .DIV(DIV), .INT_COUNTS(INT_COUNTS), .FULL_COUNTS(FULL_COUNTS),
  .CYCLE_COUNTS(CYCLE_COUNTS), .DIGITS(DIGITS)
) u_chk (
  .clk(clk), .rst(rst), .az_o(az_o), .int_o(int_o), .de_pos_o(de_pos_o),
  .de_neg_o(de_neg_o), .done_o(done_o), .reading_o(reading_o),
  .neg_o(neg_o), .ovr_o(ovr_o)
);

// File: tb/dual_slope_seq_tb.sv
`timescale 1ns/1ps
module dual_slope_seq_tb_top;
  import dsc_pkg::*;

  localparam int DIV = 4, INTC = 100, FULL = 200, CYC = 400, DIG = 4;
  localparam int RW = 4 * DIG;

  logic clk = 1'b0, rst = 1'b1, comp = 1'b0;
  logic az, intg, dep, den, done, neg, ovr;
  logic [RW-1:0] reading;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_slope_seq #(.DIV(DIV), .INT_COUNTS(INTC), .FULL_COUNTS(FULL),
                   .CYCLE_COUNTS(CYC), .DIGITS(DIG)) dut_i (
    .clk(clk), .rst(rst), .comp_i(comp), .az_o(az), .int_o(intg),
    .de_pos_o(dep), .de_neg_o(den), .done_o(done), .reading_o(reading),
    .neg_o(neg), .ovr_o(ovr));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bcd(input int v);
    logic [31:0] b;
    b = to_bcd(v);
    return int'(b[RW-1:0]);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic convert(input bit pos, input int n, inout int last_rd);
    int ilen, dlen, alen, exp_rd, exp_de, held;
    comp = pos;
    ilen = 0;
    while (intg) begin ilen++; @(negedge clk); end
    chk("R4 integrate length", ilen, INTC * DIV);
    chk("R10 reading held through cycle", int'(reading), last_rd);
    chk("R6 positive select", int'(dep), int'(pos));
    chk("R6 negative select", int'(den), int'(!pos));
    dlen = 0;
    while (dep || den) begin
      if (dlen == n * DIV) comp = !pos;
      dlen++;
      @(negedge clk);
    end
    exp_rd = (n < FULL) ? n : FULL;
    exp_de = (n < FULL) ? (n + 1) * DIV : FULL * DIV;
    chk("R10 done pulse", int'(done), 1);
    chk("R7 R11 reading", int'(reading), exp_bcd(exp_rd));
    chk("R8 overrange", int'(ovr), int'(n >= FULL));
    chk("R12 sign", int'(neg), int'(!pos));
    chk("R7 R8 R1 de length", dlen, exp_de);
    held = int'(reading);
    alen = 1;
    @(negedge clk);
    chk("R10 done one clock", int'(done), 0);
    while (az) begin alen++; @(negedge clk); end
    chk("R9 zeroing length", alen, (CYC - INTC) * DIV - dlen);
    chk("R5 cycle length", ilen + dlen + alen, CYC * DIV);
    chk("R10 reading held in zeroing", int'(reading), held);
    last_rd = held;
  endtask

  initial begin
    int alen, last_rd;
    int directed[10] = '{0, 1, 9, 10, 99, FULL - 1, FULL, FULL + 7, 100, 55};
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2 reset az", int'(az), 1);
    chk("R2 reset other phases", int'({intg, dep, den}), 0);
    chk("R2 reset flags", int'({done, neg, ovr}), 0);
    chk("R2 reset reading", int'(reading), 0);
    rst = 1'b0;
    alen = 0;
    while (az) begin alen++; @(negedge clk); end
    chk("R2 R1 first zeroing length", alen, (CYC - INTC - FULL) * DIV);
    chk("R3 R4 integrate follows", int'({az, intg, dep, den}), 4'b0100);
    last_rd = 0;
    foreach (directed[k]) convert(k[0], directed[k], last_rd);
    for (int k = 0; k < 40; k++) convert($urandom % 2 == 0, int'($urandom % (FULL + 20)), last_rd);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end
endmodule